// File: doc/BRIEF.md
# Video Scaler Input Sorter

This block sits in front of a video scaler. It takes picture data from one of two sources and splits it into two lanes. The luma lane carries luma or raw samples. The chroma lane carries Cb and Cr, which alternate in time. Each output sample is tagged with its chroma kind, a line-start flag and the field bit.

The wide source delivers one luma byte and one chroma byte on every clock. Those samples count only while an active-window input is high. The byte source delivers an interleaved stream with embedded timing references. It may pause, and a byte counts only when its qualifier is high. From the timing references the block decodes only line start and field.

An optional mode turns 4:1:1 chroma spacing into 4:2:2 by repeating chroma. A small FIFO sits between the sorter and the scaler, which drains it with a valid/request handshake. The byte source is throttled through a ready output. The wide source cannot be stalled, so a sample it loses is reported as an overrun.

Top module: `video_input_sorter`

## Requirements
- R1: After reset, out_valid_o is 0, overrun_o is 0 and byte_rdy_o is 1.
- R2: With src_sel_i=0, every clock with wide_act_i=1 yields one sample (y=wide_y_i, c=wide_c_i). Samples leave in arrival order. out_cr_o is 0 for the first sample of a window and then alternates 1,0,1,...
- R3: out_sol_o is 1 only on the first sample of a line: the first cycle of a wide_act_i window, or the first pixel after a start-of-active code. out_field_o carries wide_field_i, or the field bit of the last start-of-active code.
- R4: With src_sel_i=1, qualified bytes are taken in the repeating order Cb, Y, Cr, Y. They give samples (Y0,Cb) with out_cr_o=0, then (Y1,Cr) with out_cr_o=1. Bytes with byte_qual_i=0 are ignored.
- R5: The four bytes 0xFF,0x00,0x00,XY form a timing code, and none of them is output. The byte phase restarts at Cb. If XY bit 4 is 0, the code starts active video and XY bit 6 becomes the field. If XY bit 4 is 1, active video ends, and bytes are discarded until the next start code.
- R6: With fmt_411_i=1, samples are counted in groups of four from each line start. Samples 2 and 3 of a group carry the chroma of samples 0 and 1.
- R7: A sample transfers on each cycle with out_valid_o=1 and out_req_i=1. While out_req_i is 0, the outputs hold stable and up to DEPTH samples are kept without loss.
- R8: byte_rdy_o is 0 while the FIFO is full. A qualified byte presented while byte_rdy_o is 0 is not taken.
- R9: A wide sample that arrives while the FIFO is full and nothing is popped is dropped, and overrun_o pulses on the next cycle. If a pop falls in the same cycle, the sample is accepted and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 1 | 0 selects the wide source, 1 the byte source |
| fmt_411_i | input | 1 | Enable 4:1:1 to 4:2:2 chroma repeat |
| wide_y_i | input | DW | Wide source luma |
| wide_c_i | input | DW | Wide source chroma |
| wide_act_i | input | 1 | Wide source active-window marker |
| wide_field_i | input | 1 | Wide source field bit |
| byte_i | input | DW | Byte source data |
| byte_qual_i | input | 1 | Byte source qualifier |
| byte_rdy_o | output | 1 | Byte source may present data |
| out_valid_o | output | 1 | Output sample available |
| out_req_i | input | 1 | Downstream request |
| out_y_o | output | DW | Luma or raw lane |
| out_c_o | output | DW | Chroma lane |
| out_cr_o | output | 1 | Chroma kind: 0 Cb, 1 Cr |
| out_sol_o | output | 1 | First sample of a line |
| out_field_o | output | 1 | Field bit |
| overrun_o | output | 1 | Wide sample was dropped |

## Verification
The collision that matters happens when the FIFO is full: a wide-source push and a downstream pop can land on the same clock edge. The bench fills the FIFO while holding the request low, and lets one more wide sample fall on a full queue. It then raises the request in the same cycle as the next wide sample. It judges the result in three ways: an overrun pulse after the first drop, none after the shared cycle, and a drained sequence that holds the sample from the shared cycle but not the dropped one.

// File: rtl/vis_pkg.sv
package vis_pkg;
  typedef enum logic [1:0] {
    ST_DATA = 2'd0,
    ST_S1   = 2'd1,
    ST_S2   = 2'd2,
    ST_S3   = 2'd3
  } sync_st_e;

  localparam int META_W = 3; // sol, field, is_cr
endpackage

// File: rtl/vis_byte_asm.sv
module vis_byte_asm
  import vis_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic [DW-1:0] byte_i,
  output logic          vld_o,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] c_o,
  output logic          cr_o,
  output logic          sol_o,
  output logic          fld_o
);
  localparam int F_BIT = DW - 2;
  localparam int H_BIT = DW - 4;

  sync_st_e      st_q;
  logic [1:0]    phase_q;
  logic          act_q, sol_q, fld_q;
  logic [DW-1:0] c_q;
  logic          is_ff, is_00;

  assign is_ff = (byte_i == '1);
  assign is_00 = (byte_i == '0);

  assign vld_o = take_i && (st_q == ST_DATA) && !is_ff && act_q && phase_q[0];
  assign y_o   = byte_i;
  assign c_o   = c_q;
  assign cr_o  = phase_q[1];
  assign sol_o = sol_q;
  assign fld_o = fld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_DATA;
      phase_q <= '0;
      act_q   <= 1'b0;
      sol_q   <= 1'b0;
      fld_q   <= 1'b0;
      c_q     <= '0;
    end else if (take_i) begin
      unique case (st_q)
        ST_DATA: begin
          if (is_ff) st_q <= ST_S1;
          else if (act_q) begin
            if (!phase_q[0]) c_q <= byte_i;
            else sol_q <= 1'b0;
            phase_q <= phase_q + 2'd1;
          end
        end
        ST_S1: begin
          st_q <= is_00 ? ST_S2 : ST_DATA;
          if (!is_00) phase_q <= '0;
        end
        ST_S2: begin
          st_q <= is_00 ? ST_S3 : ST_DATA;
          if (!is_00) phase_q <= '0;
        end
        ST_S3: begin
          st_q    <= ST_DATA;
          phase_q <= '0;
          if (!byte_i[H_BIT]) begin
            act_q <= 1'b1;
            sol_q <= 1'b1;
            fld_q <= byte_i[F_BIT];
          end else begin
            act_q <= 1'b0;
          end
        end
        default: st_q <= ST_DATA;
      endcase
    end
  end

  p_realign_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_S3 && take_i) |=> (phase_q == 2'd0 && st_q == ST_DATA));

  p_no_emit_in_code_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_DATA) |-> !vld_o);
endmodule

// File: rtl/vis_up411.sv
module vis_up411 #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          vld_i,
  input  logic          sol_i,
  input  logic [DW-1:0] c_i,
  output logic [DW-1:0] c_o
);
  logic [1:0]    cnt_q, idx;
  logic [DW-1:0] cb_q, cr_q;

  assign idx = sol_i ? 2'd0 : cnt_q;

  always_comb begin
    c_o = c_i;
    if (en_i && idx == 2'd2) c_o = cb_q;
    if (en_i && idx == 2'd3) c_o = cr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cb_q  <= '0;
      cr_q  <= '0;
    end else if (vld_i) begin
      cnt_q <= idx + 2'd1;
      if (idx == 2'd0) cb_q <= c_i;
      if (idx == 2'd1) cr_q <= c_i;
    end
  end

  p_group_restart_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && sol_i) |=> (cnt_q == 2'd1));
endmodule

// File: rtl/vis_fifo.sv
module vis_fifo #(
  parameter int W     = 19,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign rdata_o = mem[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + 1'b1;
      if (pop_i)  rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(push_i) - (AW+1)'(pop_i);
    end
  end

  p_no_overflow_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> !full_o);

  p_no_underflow_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/video_input_sorter.sv
module video_input_sorter
  import vis_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          src_sel_i,
  input  logic          fmt_411_i,
  input  logic [DW-1:0] wide_y_i,
  input  logic [DW-1:0] wide_c_i,
  input  logic          wide_act_i,
  input  logic          wide_field_i,
  input  logic [DW-1:0] byte_i,
  input  logic          byte_qual_i,
  output logic          byte_rdy_o,
  output logic          out_valid_o,
  input  logic          out_req_i,
  output logic [DW-1:0] out_y_o,
  output logic [DW-1:0] out_c_o,
  output logic          out_cr_o,
  output logic          out_sol_o,
  output logic          out_field_o,
  output logic          overrun_o
);
  localparam int FW = 2 * DW + META_W;

  logic          full, empty, pop, push, drop;
  logic          byte_take;
  logic          b_vld, b_cr, b_sol, b_fld;
  logic [DW-1:0] b_y, b_c;
  logic          w_take, w_sol, w_cr, wact_q, wcr_q;
  logic          m_vld, m_cr, m_sol, m_fld;
  logic [DW-1:0] m_y, m_c, u_c;
  logic [FW-1:0] wdata, rdata;
  logic          ovr_q;

  assign pop       = !empty && out_req_i;
  assign byte_take = src_sel_i && byte_qual_i && !full;

  vis_byte_asm #(.DW(DW)) u_asm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .take_i(byte_take),
    .byte_i(byte_i),
    .vld_o (b_vld),
    .y_o   (b_y),
    .c_o   (b_c),
    .cr_o  (b_cr),
    .sol_o (b_sol),
    .fld_o (b_fld)
  );

  // wide source: line starts on rising edge of the active window
  assign w_take = !src_sel_i && wide_act_i;
  assign w_sol  = w_take && !wact_q;
  assign w_cr   = w_sol ? 1'b0 : wcr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wact_q <= 1'b0;
      wcr_q  <= 1'b0;
    end else begin
      wact_q <= w_take;
      if (w_take) wcr_q <= ~w_cr;
    end
  end

  assign m_vld = src_sel_i ? b_vld : w_take;
  assign m_y   = src_sel_i ? b_y   : wide_y_i;
  assign m_c   = src_sel_i ? b_c   : wide_c_i;
  assign m_cr  = src_sel_i ? b_cr  : w_cr;
  assign m_sol = src_sel_i ? b_sol : w_sol;
  assign m_fld = src_sel_i ? b_fld : wide_field_i;

  vis_up411 #(.DW(DW)) u_up (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (fmt_411_i),
    .vld_i (m_vld),
    .sol_i (m_sol),
    .c_i   (m_c),
    .c_o   (u_c)
  );

  assign push  = m_vld && (!full || pop);
  assign drop  = m_vld && full && !pop;
  assign wdata = {m_sol, m_fld, m_cr, m_y, u_c};

  vis_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .wdata_i(wdata),
    .pop_i  (pop),
    .rdata_o(rdata),
    .full_o (full),
    .empty_o(empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovr_q <= 1'b0;
    else         ovr_q <= drop;
  end

  assign byte_rdy_o  = !full;
  assign out_valid_o = !empty;
  assign {out_sol_o, out_field_o, out_cr_o, out_y_o, out_c_o} = rdata;
  assign overrun_o   = ovr_q;

  p_hold_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_req_i) |=>
      (out_valid_o && $stable({out_y_o, out_c_o, out_cr_o, out_sol_o, out_field_o})));

  p_overrun_wide_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> $past(!src_sel_i && wide_act_i));

  p_rdy_full_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_rdy_o |-> out_valid_o);
endmodule

// File: tb/video_input_sorter_test.sv
module video_input_sorter_test;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          src_sel = 1'b1, fmt_411 = 1'b0;
  logic [DW-1:0] wide_y = '0, wide_c = '0;
  logic          wide_act = 1'b0, wide_field = 1'b0;
  logic [DW-1:0] byte_d = '0;
  logic          byte_qual = 1'b0;
  logic          byte_rdy, out_valid, out_cr, out_sol, out_field, overrun;
  logic          out_req = 1'b1;
  logic [DW-1:0] out_y, out_c;

  int checks = 0;
  int errors = 0;
  logic timed_out = 1'b0;

  logic [18:0] rec [64];
  int rec_n = 0;

  always #10 clk = ~clk;

  video_input_sorter #(.DW(DW), .DEPTH(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .src_sel_i(src_sel), .fmt_411_i(fmt_411),
    .wide_y_i(wide_y), .wide_c_i(wide_c), .wide_act_i(wide_act),
    .wide_field_i(wide_field), .byte_i(byte_d), .byte_qual_i(byte_qual),
    .byte_rdy_o(byte_rdy), .out_valid_o(out_valid), .out_req_i(out_req),
    .out_y_o(out_y), .out_c_o(out_c), .out_cr_o(out_cr), .out_sol_o(out_sol),
    .out_field_o(out_field), .overrun_o(overrun)
  );

  // transfer monitor: records {sol,field,cr,y,c}
  always @(negedge clk) begin
    if (rst_n && out_valid && out_req && rec_n < 64) begin
      rec[rec_n] <= {out_sol, out_field, out_cr, out_y, out_c};
      rec_n <= rec_n + 1;
    end
  end

  // {qual, byte}
  localparam logic [8:0] BYTES [27] = '{
    9'h1FF, 9'h100, 9'h100, 9'h180,
    9'h110, 9'h120, 9'h130, 9'h099, 9'h121, 9'h111, 9'h122, 9'h131, 9'h123,
    9'h1FF, 9'h100, 9'h100, 9'h190,
    9'h140, 9'h141,
    9'h1FF, 9'h100, 9'h100, 9'h1C0,
    9'h112, 9'h124, 9'h132, 9'h125
  };
  // {sol, field, cr, y, c}
  localparam logic [18:0] EXP [6] = '{
    {3'b100, 8'h20, 8'h10}, {3'b001, 8'h21, 8'h30},
    {3'b000, 8'h22, 8'h11}, {3'b001, 8'h23, 8'h31},
    {3'b110, 8'h24, 8'h12}, {3'b011, 8'h25, 8'h32}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic send_byte(input logic [7:0] b);
    tick();
    byte_qual = 1'b1;
    byte_d = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      tick();
      byte_qual = 1'b0;
      wide_act = 1'b0;
    end
  endtask

  initial begin
    fork
      begin : tests
        int base;
        repeat (3) @(posedge clk);
        #5;
        // R1 reset state
        chk("R1 valid", 32'(out_valid), 32'h0);
        chk("R1 overrun", 32'(overrun), 32'h0);
        chk("R1 rdy", 32'(byte_rdy), 32'h1);
        rst_n = 1'b1;

        // table walk: byte source, R3 R4 R5
        base = rec_n;
        for (int i = 0; i < 27; i++) begin
          tick();
          byte_qual = BYTES[i][8];
          byte_d    = BYTES[i][7:0];
        end
        idle(6);
        for (int i = 0; i < 6; i++) chk("R4 R5 R3 byte sample", 32'(rec[base+i]), 32'(EXP[i]));
        chk("R5 blanking discarded", 32'(rec_n - base), 32'd6);

        // wide source, R2 R3
        src_sel = 1'b0;
        idle(1);
        base = rec_n;
        for (int i = 0; i < 4; i++) begin
          tick();
          wide_act = 1'b1; wide_field = 1'b1;
          wide_y = 8'(8'h50 + i); wide_c = 8'(8'h60 + i);
        end
        idle(4);
        for (int i = 0; i < 4; i++)
          chk("R2 R3 wide sample", 32'(rec[base+i]),
              32'({(i == 0), 1'b1, 1'(i % 2), 8'(8'h50 + i), 8'(8'h60 + i)}));

        // 4:1:1 repeat, R6
        fmt_411 = 1'b1;
        base = rec_n;
        for (int i = 0; i < 6; i++) begin
          tick();
          wide_act = 1'b1; wide_field = 1'b0;
          wide_y = 8'(i); wide_c = 8'(8'h70 + i);
        end
        idle(4);
        chk("R6 c0", 32'(rec[base+0][7:0]), 32'h70);
        chk("R6 c1", 32'(rec[base+1][7:0]), 32'h71);
        chk("R6 c2 repeat", 32'(rec[base+2][7:0]), 32'h70);
        chk("R6 c3 repeat", 32'(rec[base+3][7:0]), 32'h71);
        chk("R6 c4", 32'(rec[base+4][7:0]), 32'h74);
        chk("R6 c5", 32'(rec[base+5][7:0]), 32'h75);
        fmt_411 = 1'b0;

        // hold, overrun, push+pop on full: R7 R9
        base = rec_n;
        tick();
        out_req = 1'b0;
        for (int i = 0; i < 5; i++) begin
          tick();
          wide_act = 1'b1; wide_y = 8'(8'h80 + i); wide_c = 8'h00;
          if (i == 3) begin
            chk("R7 held valid", 32'(out_valid), 32'h1);
            chk("R7 held data", 32'(out_y), 32'h80);
          end
        end
        tick();
        chk("R9 overrun on drop", 32'(overrun), 32'h1);
        chk("R7 still held", 32'(out_y), 32'h80);
        wide_y = 8'h85; out_req = 1'b1;
        tick();
        chk("R9 no overrun with pop", 32'(overrun), 32'h0);
        chk("R8 rdy low when full", 32'(byte_rdy), 32'h0);
        wide_act = 1'b0;
        idle(8);
        chk("R7 drain0", 32'(rec[base+0][15:8]), 32'h80);
        chk("R7 drain1", 32'(rec[base+1][15:8]), 32'h81);
        chk("R7 drain2", 32'(rec[base+2][15:8]), 32'h82);
        chk("R7 drain3", 32'(rec[base+3][15:8]), 32'h83);
        chk("R9 drain4 shared cycle", 32'(rec[base+4][15:8]), 32'h85);
        chk("R9 drop count", 32'(rec_n - base), 32'd5);

        // byte back-pressure, R8
        src_sel = 1'b1;
        out_req = 1'b0;
        idle(1);
        base = rec_n;
        send_byte(8'hFF); send_byte(8'h00); send_byte(8'h00); send_byte(8'h80);
        for (int i = 0; i < 4; i++) begin
          send_byte(8'(8'hA0 + i));
          send_byte(8'(8'hB0 + i));
        end
        tick();
        byte_qual = 1'b0;
        chk("R8 rdy low full", 32'(byte_rdy), 32'h0);
        send_byte(8'h77);
        send_byte(8'h77);
        tick();
        byte_qual = 1'b0;
        out_req = 1'b1;
        idle(6);
        send_byte(8'h13);
        send_byte(8'h26);
        idle(5);
        for (int i = 0; i < 4; i++)
          chk("R8 R4 queued", 32'(rec[base+i][15:0]), 32'({8'(8'hB0 + i), 8'(8'hA0 + i)}));
        chk("R8 byte ignored while not ready", 32'(rec[base+4][15:0]), 32'h2613);
      end
      begin : watchdog
        repeat (20000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule